// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Format Checking

This block turns a single asynchronous serial line back into bytes. A bit timer driven by a tick at sixteen times the baud rate finds the falling edge of a start bit. It confirms the start bit near its middle and then samples every later bit at its midpoint. The frame layout is set by a 6-bit line-control word, the same word that drives the matching transmitter. That word selects the data length, parity on or off, odd, even or forced parity, and it shares its layout with the transmitter.

When a frame ends, the block presents the received byte together with a data-ready flag. It also reports a parity error and a framing error for that frame. A read strobe takes the byte and clears data ready. If a new byte arrives before the old one has been read, the overrun flag is raised and the new byte replaces the old one. A glitch that pulls the line low but is high again at mid-bit is ignored as a false start.

Top module: `serial_rx_core`

## Requirements
- R1: Word length follows line_ctl[1:0]: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8 data bits, received LSB first. Byte bits at and above the word length read as 0.
- R2: After a valid frame, rx_byte holds the received data and data_ready is 1. rx_byte changes only when a frame completes.
- R3: If the line is high again at the mid-start-bit check, the start is false: no frame completes and data_ready stays 0. A following valid frame is received correctly.
- R4: With line_ctl[3]=1 and line_ctl[5]=0, a parity bit follows the data. line_ctl[4]=0 expects an odd number of ones over data plus parity, and line_ctl[4]=1 expects an even number. parity_err is 1 after a frame whose parity bit violates this and 0 otherwise.
- R5: With line_ctl[3]=1 and line_ctl[5]=1, the expected parity bit is the inverse of line_ctl[4], whatever the data.
- R6: With line_ctl[3]=0 no parity bit is received, the stop bit follows the last data bit, and parity_err is 0.
- R7: Only the first stop bit is checked. frame_err is 1 after a frame whose stop bit is sampled low and 0 otherwise. line_ctl[2] has no effect on reception.
- R8: A one-cycle rd_strobe clears data_ready and overrun, unless a frame completes in that same cycle.
- R9: If a frame completes while data_ready is 1 and no read strobe is present, overrun becomes 1 and rx_byte takes the new byte.
- R10: After reset, data_ready, overrun, parity_err and frame_err are 0 and rx_byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse at sixteen times the baud rate |
| rxd | input | 1 | Serial input line, idle high |
| line_ctl | input | 6 | Frame format: [1:0] length, [2] stop length (unused here), [3] parity enable, [4] even select, [5] forced parity |
| rd_strobe | input | 1 | Read strobe; takes the byte and clears the flags |
| rx_byte | output | 8 | Received data, zero-filled above the word length |
| data_ready | output | 1 | A received byte is waiting |
| parity_err | output | 1 | Parity error in the last received frame |
| frame_err | output | 1 | Framing error in the last received frame |
| overrun | output | 1 | A byte was replaced before it was read |

## Verification
The receiver is first driven with all-ones bytes at each of the four word lengths. Any bit above the selected length that reads as one then shows up directly, so wrong length decoding or missing zero-fill is caught. Directed frames then cover odd and even parity with the parity bit right and wrong, and forced parity under both sense settings with data chosen to disagree with computed parity. Further directed frames cover a low stop bit, a short low glitch that must be rejected, and two unread frames in a row. Random frames with random format, data and injected errors follow, and each one is checked against byte and flag values computed in the bench from the format word.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;

  // line-control field positions (shared with the transmitter)
  localparam int LC_LEN_LO = 0;
  localparam int LC_PAR_EN = 3;
  localparam int LC_EVEN   = 4;
  localparam int LC_FORCE  = 5;

endpackage

// File: rtl/rx_frame_sampler.sv
module rx_frame_sampler
  import serial_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  output logic [DATA_W-1:0] data_q,
  output logic              par_bit_q,
  output logic              stop_bit_q,
  output logic              frame_done
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);

  rx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bidx;
  logic [IDX_W-1:0] last_idx;
  logic             line_s;
  logic             line_prev;

  assign last_idx = IDX_W'(32'(len_sel) + 4);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_s <= 1'b1;
    end else begin
      line_s <= rxd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      cnt        <= '0;
      bidx       <= '0;
      line_prev  <= 1'b1;
      data_q     <= '0;
      par_bit_q  <= 1'b0;
      stop_bit_q <= 1'b1;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (tick) begin
        line_prev <= line_s;
        unique case (state)
          RX_IDLE: begin
            if (!line_s && line_prev) begin
              state <= RX_START;
              cnt   <= CNT_W'(1);
            end
          end
          RX_START: begin
            if (cnt == MID_CNT) begin
              cnt <= '0;
              if (line_s) begin
                state <= RX_IDLE;
              end else begin
                state  <= RX_DATA;
                bidx   <= '0;
                data_q <= '0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_CNT) begin
              data_q[bidx] <= line_s;
              if (bidx == last_idx) begin
                state <= par_en ? RX_PAR : RX_STOP;
              end else begin
                bidx <= bidx + 1'b1;
              end
            end
          end
          RX_PAR: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_CNT) begin
              par_bit_q <= line_s;
              state     <= RX_STOP;
            end
          end
          RX_STOP: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_CNT) begin
              stop_bit_q <= line_s;
              frame_done <= 1'b1;
              state      <= RX_IDLE;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_parity_check.sv
module rx_parity_check #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par_bit,
  input  logic              par_en,
  input  logic              even_sel,
  input  logic              force_sel,
  output logic              par_err
);
  logic expect_bit;

  always_comb begin
    if (force_sel) begin
      expect_bit = ~even_sel;
    end else if (even_sel) begin
      expect_bit = ^data;
    end else begin
      expect_bit = ~^data;
    end
    par_err = par_en && (par_bit != expect_bit);
  end
endmodule

// File: rtl/rx_hold_regs.sv
module rx_hold_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] data_in,
  input  logic              par_err_in,
  input  logic              stop_bit_in,
  output logic [DATA_W-1:0] rx_byte,
  output logic              data_ready,
  output logic              parity_err,
  output logic              frame_err,
  output logic              overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte    <= '0;
      data_ready <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      overrun    <= 1'b0;
    end else if (frame_done) begin
      rx_byte    <= data_in;
      data_ready <= 1'b1;
      parity_err <= par_err_in;
      frame_err  <= ~stop_bit_in;
      overrun    <= (overrun | data_ready) & ~rd_strobe;
    end else if (rd_strobe) begin
      data_ready <= 1'b0;
      overrun    <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rxd,
  input  logic [5:0]        line_ctl,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              data_ready,
  output logic              parity_err,
  output logic              frame_err,
  output logic              overrun
);
  logic [DATA_W-1:0] data_w;
  logic              par_bit_w;
  logic              stop_bit_w;
  logic              frame_done_w;
  logic              par_err_w;
  logic              unused_stop_len;

  // stop-length bit only matters to the transmitter
  assign unused_stop_len = line_ctl[2];

  rx_frame_sampler #(.OVS(OVS), .DATA_W(DATA_W)) u_sampler (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick16),
    .rxd        (rxd),
    .len_sel    (line_ctl[LC_LEN_LO +: 2]),
    .par_en     (line_ctl[LC_PAR_EN]),
    .data_q     (data_w),
    .par_bit_q  (par_bit_w),
    .stop_bit_q (stop_bit_w),
    .frame_done (frame_done_w)
  );

  rx_parity_check #(.DATA_W(DATA_W)) u_parity (
    .data      (data_w),
    .par_bit   (par_bit_w),
    .par_en    (line_ctl[LC_PAR_EN]),
    .even_sel  (line_ctl[LC_EVEN]),
    .force_sel (line_ctl[LC_FORCE]),
    .par_err   (par_err_w)
  );

  rx_hold_regs #(.DATA_W(DATA_W)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .frame_done  (frame_done_w),
    .rd_strobe   (rd_strobe),
    .data_in     (data_w),
    .par_err_in  (par_err_w),
    .stop_bit_in (stop_bit_w),
    .rx_byte     (rx_byte),
    .data_ready  (data_ready),
    .parity_err  (parity_err),
    .frame_err   (frame_err),
    .overrun     (overrun)
  );
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_strobe,
  input logic [5:0]        line_ctl,
  input logic              frame_done,
  input logic [DATA_W-1:0] rx_byte,
  input logic              data_ready,
  input logic              parity_err,
  input logic              overrun
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!data_ready && !overrun && rx_byte == '0)); // R10
  AST_READY_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst) frame_done |=> data_ready); // R2
  AST_BYTE_HOLDS: assert property (@(posedge clk) disable iff (rst) !frame_done |=> $stable(rx_byte)); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst) (rd_strobe && !frame_done) |=> (!data_ready && !overrun)); // R8
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst) (frame_done && data_ready && !rd_strobe) |=> overrun); // R9
  AST_NO_PAR_ERR_OFF: assert property (@(posedge clk) disable iff (rst) (frame_done && !line_ctl[3]) |=> !parity_err); // R6
  AST_ZERO_FILL_5: assert property (@(posedge clk) disable iff (rst) (frame_done && line_ctl[1:0] == 2'b00) |=> rx_byte[7:5] == 3'b000); // R1
endmodule

bind serial_rx_core serial_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_strobe  (rd_strobe),
  .line_ctl   (line_ctl),
  .frame_done (frame_done_w),
  .rx_byte    (rx_byte),
  .data_ready (data_ready),
  .parity_err (parity_err),
  .overrun    (overrun)
);

// File: tb/test_serial_rx_core.sv
`timescale 1ns/1ps
module test_serial_rx_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [5:0] line_ctl = 6'd0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_byte;
  logic       data_ready, parity_err, frame_err, overrun;
  logic [1:0] tdiv = 2'd0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  serial_rx_core i_serial_rx_core (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .line_ctl(line_ctl),
    .rd_strobe(rd_strobe), .rx_byte(rx_byte), .data_ready(data_ready),
    .parity_err(parity_err), .frame_err(frame_err), .overrun(overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!tick16) @(negedge clk);
    end
  endtask

  function automatic logic [7:0] mask_of(input logic [5:0] lc);
    return 8'hFF >> (3 - lc[1:0]);
  endfunction

  function automatic logic good_par(input logic [7:0] d, input logic [5:0] lc);
    logic [7:0] m;
    m = d & mask_of(lc);
    if (lc[5]) return ~lc[4];
    return lc[4] ? ^m : ~^m;
  endfunction

  task automatic send_frame(input logic [7:0] d, input logic [5:0] lc,
                            input bit flip_par, input bit bad_stop);
    int n;
    n = 5 + int'(lc[1:0]);
    line_ctl = lc;
    rxd = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < n; i++) begin
      rxd = d[i];
      wait_ticks(16);
    end
    if (lc[3]) begin
      rxd = good_par(d, lc) ^ flip_par;
      wait_ticks(16);
    end
    rxd = ~bad_stop;
    wait_ticks(16);
    rxd = 1'b1;
    wait_ticks(bad_stop ? 20 : 4);
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic frame_and_check(input string req, input logic [7:0] d,
                                 input logic [5:0] lc, input bit fp, input bit bs);
    send_frame(d, lc, fp, bs);
    check({req, " data_ready"}, int'(data_ready), 1);
    check({req, " rx_byte"}, int'(rx_byte), int'(d & mask_of(lc)));
    check({req, " parity_err"}, int'(parity_err), int'(lc[3] & fp));
    check({req, " frame_err"}, int'(frame_err), int'(bs));
    check({req, " overrun"}, int'(overrun), 0);
    do_read();
    check("R8 read clears data_ready", int'(data_ready), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0451));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 data_ready", int'(data_ready), 0);
    check("R10 overrun", int'(overrun), 0);
    check("R10 parity_err", int'(parity_err), 0);
    check("R10 frame_err", int'(frame_err), 0);
    check("R10 rx_byte", int'(rx_byte), 0);
    wait_ticks(4);

    // R1 each length with all ones, parity off (R6)
    for (int l = 0; l < 4; l++) frame_and_check("R1 R6", 8'hFF, 6'(l), 1'b0, 1'b0);
    // R4 odd / even, good and bad
    frame_and_check("R4 odd ok", 8'hA5, 6'b001011, 1'b0, 1'b0);
    frame_and_check("R4 odd bad", 8'hA5, 6'b001011, 1'b1, 1'b0);
    frame_and_check("R4 even ok", 8'h37, 6'b011011, 1'b0, 1'b0);
    frame_and_check("R4 even bad", 8'h37, 6'b011010, 1'b1, 1'b0);
    // R5 forced parity: data 0x01 makes computed parity differ
    frame_and_check("R5 force sel0", 8'h01, 6'b101011, 1'b0, 1'b0);
    frame_and_check("R5 force sel1", 8'h01, 6'b111011, 1'b0, 1'b0);
    frame_and_check("R5 force bad", 8'h03, 6'b111011, 1'b1, 1'b0);
    // R7 framing error, and stop-length bit ignored
    frame_and_check("R7 bad stop", 8'h5A, 6'b000111, 1'b0, 1'b1);
    frame_and_check("R7 stop-len bit", 8'hC3, 6'b000111, 1'b0, 1'b0);

    // R3 false start: short low glitch
    line_ctl = 6'b000011;
    rxd = 1'b0;
    wait_ticks(3);
    rxd = 1'b1;
    wait_ticks(200);
    check("R3 false start no data", int'(data_ready), 0);
    check("R3 false start byte kept", int'(rx_byte), 8'hC3);
    frame_and_check("R3 after glitch", 8'h96, 6'b000011, 1'b0, 1'b0);

    // R9 overrun: two frames unread
    send_frame(8'h11, 6'b000011, 1'b0, 1'b0);
    check("R9 first no overrun", int'(overrun), 0);
    send_frame(8'h22, 6'b000011, 1'b0, 1'b0);
    check("R9 overrun set", int'(overrun), 1);
    check("R9 new byte", int'(rx_byte), 8'h22);
    do_read();
    check("R8 overrun cleared", int'(overrun), 0);
    check("R8 data_ready cleared", int'(data_ready), 0);

    // random frames
    for (int k = 0; k < 30; k++) begin
      logic [7:0] d;
      logic [5:0] lc;
      bit fp, bs;
      d  = 8'($urandom);
      lc = 6'($urandom);
      fp = ($urandom % 4) == 0;
      bs = ($urandom % 5) == 0;
      frame_and_check("R2 random", d, lc, fp, bs);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule